// File: doc/BRIEF.md
# Programmable Digital Delay Line

This block copies a single-bit signal to its output after a delay chosen by an address. The delay has two parts. The first is a fixed inherent part of `BASE_DLY` sample clocks. The second is the address times one sample clock. With the default 8-bit address, any total delay from `BASE_DLY` to `BASE_DLY + 255` cycles can be selected. The signal is neither inverted nor reshaped. Rising and falling edges see the same delay, so pulse widths pass through unchanged.

The active address can come from two sources, chosen by `mode_ser`:

- **Parallel bus.** The address follows `par_addr` while `addr_en` is high.
- **Serial shift interface.** A serial clock and data pair shift a word in, most significant bit first. The shift register's top bit is driven out on `ser_dout`, so several lines can be chained on one serial path. A rising edge of `addr_en` commits the shifted word.

`ser_clk` and `addr_en` are sampled by the sample clock. A change of address takes effect on the next sample clock. It does not flush the stored history.

Top module: `prog_delay_line`

## Requirements
- R1: With active address A, `sig_out` in cycle n equals `sig_in` in cycle n-D, where D = BASE_DLY + A. There is no inversion.
- R2: Address 0 gives a delay of exactly BASE_DLY cycles, and address 2^ADDR_W-1 gives BASE_DLY + 2^ADDR_W - 1 cycles.
- R3: A high pulse of W cycles on `sig_in` appears on `sig_out` as a high pulse of W cycles.
- R4: With `mode_ser` = 0 (parallel), each clock edge at which `addr_en` is high loads `par_addr` into the active address. The new address is used from the cycle after that edge.
- R5: At any clock edge at which `addr_en` is low, the active address keeps its value, in either mode.
- R6: With `mode_ser` = 1 (serial), the serial word shifts left by one place, taking `ser_din` into bit 0. This happens at a clock edge where `ser_clk` is sampled 1, was sampled 0 at the previous edge, and `addr_en` is low. The first bit sent becomes the address MSB after ADDR_W shifts.
- R7: `ser_dout` always shows bit ADDR_W-1 of the serial word. The word does not change when `mode_ser` = 0 or when `addr_en` is high.
- R8: With `mode_ser` = 1, a clock edge at which `addr_en` is sampled 1 after being sampled 0 at the previous edge loads the serial word into the active address. `par_addr` has no effect in this mode.
- R9: Changing the address does not clear the delay history. After the change, the output follows R1 with the new address, using inputs stored before the change.
- R10: A clock edge with `rst` high clears the delay history, the active address and the serial word. `sig_out` and `ser_dout` then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one delay step per period |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Signal to be delayed |
| sig_out | output | 1 | Delayed copy of `sig_in` |
| mode_ser | input | 1 | Address source: 0 parallel bus, 1 serial interface |
| addr_en | input | 1 | Address enable: level in parallel mode, rising edge commits in serial mode |
| par_addr | input | ADDR_W | Parallel address bus |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_din | input | 1 | Serial address data, MSB first |
| ser_dout | output | 1 | Top bit of the serial word, for chaining |

## Verification
The bench builds the block with its defaults: ADDR_W = 8, BASE_DLY = 2 and the tree tap multiplexer. This puts both ends of the delay range within reach: 2 cycles at address 0 and 257 at address 255. Every tap leaf and every tree level of the 257-stage history is exercised. Pulse measurements at addresses 0, 100, 255 and a serially loaded 7 pin the exact delay and pulse width. A running reference model follows random input across address changes made without flushing, serial words shifted through `ser_dout`, and shift or load attempts that must be ignored.

// File: rtl/dly_pkg.sv
package dly_pkg;

   // Address source selected by the mode input
   typedef enum logic {
      SRC_PARALLEL = 1'b0,
      SRC_SERIAL   = 1'b1
   } addr_src_e;

   // Number of history stages: every address tap plus the inherent part
   function automatic int chain_depth(input int addr_w, input int base_dly);
      return (1 << addr_w) - 1 + base_dly;
   endfunction

endpackage

// File: rtl/dly_serial_port.sv
module dly_serial_port
   import dly_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_ser,
   input  logic              addr_en,
   input  logic              ser_clk,
   input  logic              ser_din,
   output logic [ADDR_W-1:0] ser_word,
   output logic              ser_dout,
   output logic              commit
);

   logic      sclk_q;
   logic      ae_q;
   logic      shift_ok;
   addr_src_e src;

   assign src = addr_src_e'(mode_ser);

   // Previous samples of the slow control inputs (edge detection only)
   always_ff @(posedge clk) begin
      sclk_q <= ser_clk;
      ae_q   <= addr_en;
   end

   assign shift_ok = (src == SRC_SERIAL) && !addr_en && ser_clk && !sclk_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ser_word <= '0;
      end else if (shift_ok) begin
         ser_word <= {ser_word[ADDR_W-2:0], ser_din};
      end
   end

   assign ser_dout = ser_word[ADDR_W-1];
   assign commit   = addr_en && !ae_q;

endmodule

// File: rtl/dly_addr_ctrl.sv
module dly_addr_ctrl
   import dly_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_ser,
   input  logic              addr_en,
   input  logic              commit,
   input  logic [ADDR_W-1:0] par_addr,
   input  logic [ADDR_W-1:0] ser_word,
   output logic [ADDR_W-1:0] act_addr
);

   addr_src_e         src;
   logic [ADDR_W-1:0] nxt_addr;

   assign src = addr_src_e'(mode_ser);

   always_comb begin
      nxt_addr = act_addr;
      unique case (src)
         SRC_PARALLEL: if (addr_en) nxt_addr = par_addr;
         SRC_SERIAL:   if (commit)  nxt_addr = ser_word;
         default:      nxt_addr = act_addr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         act_addr <= '0;
      end else begin
         act_addr <= nxt_addr;
      end
   end

endmodule

// File: rtl/dly_tap_chain.sv
module dly_tap_chain
   import dly_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int BASE_DLY = 2,
   parameter bit TREE_MUX = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sig_in,
   input  logic [ADDR_W-1:0] tap_sel,
   output logic              tap_bit
);

   localparam int NLEAF = 1 << ADDR_W;
   localparam int DEPTH = chain_depth(ADDR_W, BASE_DLY);

   logic [DEPTH-1:0] chain_q;
   logic [NLEAF-1:0] leaf;

   // History shift register; stage k holds the input of k+1 cycles ago
   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[DEPTH-2:0], sig_in};
      end
   end

   // Leaf j is the stage giving a total delay of BASE_DLY + j
   for (genvar j = 0; j < NLEAF; j++) begin : g_leaf
      assign leaf[j] = chain_q[BASE_DLY-1+j];
   end

   if (TREE_MUX) begin : g_tree
      // Balanced 2:1 tree, one level per address bit, LSB first
      for (genvar lv = 0; lv <= ADDR_W; lv++) begin : g_lvl
         logic [(NLEAF>>lv)-1:0] v;
         if (lv == 0) begin : g_base
            assign v = leaf;
         end else begin : g_node
            for (genvar k = 0; k < (NLEAF >> lv); k++) begin : g_k
               assign v[k] = tap_sel[lv-1] ? g_lvl[lv-1].v[2*k+1]
                                           : g_lvl[lv-1].v[2*k];
            end
         end
      end
      assign tap_bit = g_lvl[ADDR_W].v[0];
   end else begin : g_flat
      assign tap_bit = leaf[tap_sel];
   end

endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
   import dly_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int BASE_DLY = 2,
   parameter bit TREE_MUX = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sig_in,
   output logic              sig_out,
   input  logic              mode_ser,
   input  logic              addr_en,
   input  logic [ADDR_W-1:0] par_addr,
   input  logic              ser_clk,
   input  logic              ser_din,
   output logic              ser_dout
);

   // Elaboration-time parameter checks
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_aw
      $error("prog_delay_line: ADDR_W must lie in 2..12");
   end
   if (BASE_DLY < 1) begin : g_bad_base
      $error("prog_delay_line: BASE_DLY must be at least 1");
   end

   logic [ADDR_W-1:0] ser_word;
   logic [ADDR_W-1:0] act_addr;
   logic              commit;

   dly_serial_port #(.ADDR_W(ADDR_W)) u_ser (
      .clk      (clk),
      .rst      (rst),
      .mode_ser (mode_ser),
      .addr_en  (addr_en),
      .ser_clk  (ser_clk),
      .ser_din  (ser_din),
      .ser_word (ser_word),
      .ser_dout (ser_dout),
      .commit   (commit)
   );

   dly_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst      (rst),
      .mode_ser (mode_ser),
      .addr_en  (addr_en),
      .commit   (commit),
      .par_addr (par_addr),
      .ser_word (ser_word),
      .act_addr (act_addr)
   );

   dly_tap_chain #(
      .ADDR_W   (ADDR_W),
      .BASE_DLY (BASE_DLY),
      .TREE_MUX (TREE_MUX)
   ) u_chain (
      .clk     (clk),
      .rst     (rst),
      .sig_in  (sig_in),
      .tap_sel (act_addr),
      .tap_bit (sig_out)
   );

endmodule

// File: rtl/dly_line_chk.sv
module dly_line_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              mode_ser,
   input logic              addr_en,
   input logic [ADDR_W-1:0] par_addr,
   input logic              ser_clk,
   input logic              ser_din,
   input logic              ser_dout,
   input logic              sig_out,
   input logic [ADDR_W-1:0] act_addr,
   input logic [ADDR_W-1:0] ser_word
);

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (sig_out == 1'b0 && ser_dout == 1'b0 && act_addr == '0)); // R10

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !addr_en |=> $stable(act_addr)); // R5

   AST_PAR_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!mode_ser && addr_en) |=> act_addr == $past(par_addr)); // R4

   AST_SER_COMMIT: assert property (@(posedge clk) disable iff (rst)
      (mode_ser && addr_en && !$past(addr_en)) |=> act_addr == $past(ser_word)); // R8

   AST_SER_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (mode_ser && !addr_en && ser_clk && !$past(ser_clk))
      |=> ser_word == {$past(ser_word[ADDR_W-2:0]), $past(ser_din)}); // R6

   AST_SER_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!mode_ser || addr_en) |=> $stable(ser_word)); // R7

endmodule

bind prog_delay_line dly_line_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mode_ser (mode_ser),
   .addr_en  (addr_en),
   .par_addr (par_addr),
   .ser_clk  (ser_clk),
   .ser_din  (ser_din),
   .ser_dout (ser_dout),
   .sig_out  (sig_out),
   .act_addr (act_addr),
   .ser_word (ser_word)
);

// File: tb/prog_delay_line_tb_top.sv
module prog_delay_line_tb_top;

   localparam int ADDR_W   = 8;
   localparam int BASE_DLY = 2;
   localparam int DEPTH    = (1 << ADDR_W) - 1 + BASE_DLY;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              sig_in = 1'b0;
   logic              sig_out;
   logic              mode_ser = 1'b0;
   logic              addr_en = 1'b0;
   logic [ADDR_W-1:0] par_addr = '0;
   logic              ser_clk = 1'b0;
   logic              ser_din = 1'b0;
   logic              ser_dout;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    rand_on  = 1'b0;
   bit    done     = 1'b0;
   bit    mdl_ok   = 1'b0;
   string tag      = "R10";
   logic [15:0] lfsr = 16'hACE1;

   // Reference model state
   bit hist[$];
   int m_addr = 0;
   int m_sreg = 0;
   bit m_psc  = 1'b0;
   bit m_pae  = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   prog_delay_line #(.ADDR_W(ADDR_W), .BASE_DLY(BASE_DLY)) dut_i (
      .clk      (clk),
      .rst      (rst),
      .sig_in   (sig_in),
      .sig_out  (sig_out),
      .mode_ser (mode_ser),
      .addr_en  (addr_en),
      .par_addr (par_addr),
      .ser_clk  (ser_clk),
      .ser_din  (ser_din),
      .ser_dout (ser_dout)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural model, updated at each rising edge from the inputs held there
   always @(posedge clk) begin
      if (rst) begin
         hist.delete();
         for (int i = 0; i < DEPTH; i++) hist.push_back(1'b0);
         m_addr = 0;
         m_sreg = 0;
         mdl_ok = 1'b1;
      end else if (mdl_ok) begin
         hist.push_front(sig_in);
         void'(hist.pop_back());
         if (mode_ser) begin
            if (ser_clk && !m_psc && !addr_en)
               m_sreg = ((m_sreg << 1) | int'(ser_din)) & ((1 << ADDR_W) - 1);
            if (addr_en && !m_pae)
               m_addr = m_sreg;
         end else if (addr_en) begin
            m_addr = int'(par_addr);
         end
      end
      m_psc = ser_clk;
      m_pae = addr_en;
   end

   // Compare on every cycle, away from the rising edge
   always @(negedge clk) begin
      if (mdl_ok && !done) begin
         check(sig_out === hist[BASE_DLY + m_addr - 1], tag, "sig_out vs model",
               int'(sig_out), int'(hist[BASE_DLY + m_addr - 1]));
         check(ser_dout === m_sreg[ADDR_W-1], tag, "ser_dout vs model",
               int'(ser_dout), int'(m_sreg[ADDR_W-1]));
      end
   end

   // Random input source
   initial begin
      forever begin
         @(negedge clk);
         if (rand_on) begin
            lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sig_in = lfsr[0];
         end
      end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Send one 5-cycle pulse and measure delay and width at the output
   task automatic measure(input int exp_d, input string req);
      int rise_k = -1;
      int fall_k = -1;
      rand_on = 1'b0;
      @(negedge clk);
      sig_in = 1'b0;
      cycles(DEPTH + 4);
      sig_in = 1'b1;
      for (int k = 1; k <= DEPTH + 20; k++) begin
         @(negedge clk);
         if (k == 5) sig_in = 1'b0;
         if (rise_k < 0 && sig_out) rise_k = k;
         else if (rise_k >= 0 && fall_k < 0 && !sig_out) fall_k = k;
      end
      check(rise_k == exp_d, req, "pulse delay", rise_k, exp_d);
      check(fall_k - rise_k == 5, "R3", "pulse width", fall_k - rise_k, 5);
   endtask

   task automatic shift_word(input int w);
      for (int b = ADDR_W - 1; b >= 0; b--) begin
         @(negedge clk);
         ser_din = w[b];
         ser_clk = 1'b0;
         @(negedge clk);
         ser_clk = 1'b1;
         @(negedge clk);
         ser_clk = 1'b0;
      end
   endtask

   task automatic commit_word;
      @(negedge clk);
      addr_en = 1'b1;
      cycles(2);
      addr_en = 1'b0;
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      bit snap;
      cycles(3);
      rst = 1'b0;
      @(negedge clk);
      check(sig_out == 1'b0, "R10", "sig_out after reset", int'(sig_out), 0);
      check(ser_dout == 1'b0, "R10", "ser_dout after reset", int'(ser_dout), 0);

      // Parallel mode: delay range ends and a middle value
      tag = "R1 R4";
      addr_en  = 1'b1;
      par_addr = 8'd0;
      rand_on  = 1'b1;
      cycles(40);
      tag = "R2";
      measure(BASE_DLY, "R2");
      par_addr = 8'd255;
      measure(BASE_DLY + 255, "R2");
      tag = "R1";
      par_addr = 8'd100;
      measure(BASE_DLY + 100, "R1");

      // Address changes without flushing the history
      tag = "R9";
      rand_on  = 1'b1;
      par_addr = 8'd10;
      cycles(300);
      par_addr = 8'd200;
      cycles(300);
      par_addr = 8'd3;
      cycles(20);

      // Enable low: bus changes ignored
      tag = "R5";
      addr_en  = 1'b0;
      par_addr = 8'd77;
      cycles(300);

      // Serial mode: shift, chain out, commit
      tag = "R6 R8";
      mode_ser = 1'b1;
      shift_word(8'hA5);
      check(ser_dout == 1'b1, "R6", "MSB after shifting A5", int'(ser_dout), 1);
      commit_word();
      cycles(300);
      tag = "R7";
      shift_word(8'h3C);
      check(ser_dout == 1'b0, "R7", "MSB after shifting 3C", int'(ser_dout), 0);
      commit_word();
      cycles(300);

      // Serial clock ignored while enable is high, and in parallel mode
      tag = "R7";
      snap = ser_dout;
      addr_en = 1'b1;
      ser_din = ~snap;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk) ser_clk = 1'b1;
         @(negedge clk) ser_clk = 1'b0;
      end
      @(negedge clk);
      check(ser_dout == snap, "R7", "no shift with enable high", int'(ser_dout), int'(snap));
      addr_en  = 1'b0;
      mode_ser = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk) ser_clk = 1'b1;
         @(negedge clk) ser_clk = 1'b0;
      end
      @(negedge clk);
      check(ser_dout == snap, "R7", "no shift in parallel mode", int'(ser_dout), int'(snap));

      // Serial mode ignores the parallel bus
      tag = "R8";
      mode_ser = 1'b1;
      addr_en  = 1'b1;
      par_addr = 8'd250;
      cycles(300);
      addr_en = 1'b0;
      shift_word(8'h07);
      commit_word();
      measure(BASE_DLY + 7, "R8");

      // Reset in the middle of traffic
      tag = "R10";
      rand_on = 1'b1;
      cycles(50);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(sig_out == 1'b0, "R10", "sig_out after mid reset", int'(sig_out), 0);
      check(ser_dout == 1'b0, "R10", "ser_dout after mid reset", int'(ser_dout), 0);
      cycles(100);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule